// File: doc/BRIEF.md
# Serial-Loaded Segment Display Driver

This block takes display data one bit at a time on a serial line and drives one output per display segment. A select input that is active low gates a shift register. Each falling edge of the serial clock moves the register along by one stage while the select is low. A load input copies the register into a parallel holding register. The outputs are driven from the holding register, so the display stays steady while new data is shifted in. If load is held high, the holding register follows the shift register.

Each segment output is the exclusive-OR of its held bit with a backplane square wave. A held 1 therefore drives the segment in antiphase to the backplane, which makes it visible. A held 0 keeps the segment in phase with the backplane, which leaves it blank. A mode input picks the backplane source. It is either a free-running display clock divided by 256, or that same display clock passed straight through. The serial output is re-timed on the rising edge of the serial clock from a fixed register stage. Several drivers can therefore be chained with shared clock, load and select lines.

All pin-level inputs are sampled by a fast system clock `clk`. Edges of the serial clock and the display clock are detected in that domain.

Top module: `serial_seg_driver`

## Requirements
- R1: A synchronous reset (`rst` high) clears the shift register, the holding register, `ser_dout` and the prescaler. After reset in divided mode, `bp_out` is 0 and every segment output equals `bp_out`.
- R2: On the `clk` cycle that sees `ser_clk` fall while `sel_n` is 0, the register shifts by one. `ser_din` enters stage 1 (bit 0), and stage k moves to stage k+1. Segment k (bit k-1 of `seg_out`) corresponds to stage k.
- R3: While `sel_n` is 1, falling edges of `ser_clk` leave the shift register unchanged.
- R4: `ser_dout` changes only on the `clk` cycle that sees `ser_clk` rise. It then takes the value of stage `TAP`, where `TAP` is one of 30, 32, 34 or 38.
- R5: While `load` is 0, the holding register keeps its value. A cycle with `load` at 1 copies the shift register into it.
- R6: While `load` stays 1 during shifting, the holding register equals the shift register after every shift, with no extra cycle of lag.
- R7: `seg_out[k]` is the held bit k XOR `bp_out`. A held 1 is in antiphase with the backplane and a held 0 is in phase with it.
- R8: With `bp_mode` = 0, the prescaler counts rising edges of `disp_clk`. `bp_out` is its most significant bit: 0 for the first 128 edges after reset, then 1 for the next 128, and so on with period 256.
- R9: With `bp_mode` = 1, `bp_out` equals `disp_clk` as sampled one `clk` cycle earlier.
- R10: Two drivers chained from `ser_dout` into `ser_din`, sharing `ser_clk`, `sel_n` and `load`, behave as one longer register. The downstream device takes the bit that the upstream device put out on the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pin-level inputs |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock: shift on its fall, output re-time on its rise |
| ser_din | input | 1 | Serial data in |
| sel_n | input | 1 | Device select, active low, gating the shift |
| load | input | 1 | Transfer the shift register to the holding register while high |
| disp_clk | input | 1 | Display clock: oscillator input or external backplane clock |
| bp_mode | input | 1 | Backplane source: 0 divided display clock, 1 display clock direct |
| seg_out | output | NSTAGE | Per-segment drive levels |
| bp_out | output | 1 | Backplane square wave |
| ser_dout | output | 1 | Re-timed serial output for chaining |

## Verification
The bench chains two drivers with different taps (32 and 38) and compares both against a bit-level model of the two registers.

- It checks `ser_dout` both between the falling and rising serial edges and after the rising edge. A design that re-timed on the falling edge would corrupt the downstream device in the chain.
- It shifts with the select high and then loads, to catch a register that ignores the select.
- It checks the holding register after every shift with load held high. A one-cycle lag there would show as stale segments.
- It steps the display clock to 127, 128, 255 and 256 edges. A prescaler with the wrong width or the wrong bit picked would flip the backplane at the wrong count.
- It toggles the direct backplane mode with a known pattern held. A segment stage that ignored the selected source would lose phase with the backplane.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

   typedef enum logic {
      BP_DIVIDED  = 1'b0,
      BP_EXTERNAL = 1'b1
   } bp_src_e;

   function automatic bit tap_is_legal(input int tap, input int nstage);
      return ((tap == 30) || (tap == 32) || (tap == 34) || (tap == 38)) && (tap <= nstage);
   endfunction

endpackage

// File: rtl/sdd_edge_det.sv
module sdd_edge_det (
   input  logic clk,
   input  logic sig,
   output logic rise,
   output logic fall
);
   logic prev_q;

   // Not reset on purpose: it only tracks the pin, so no false edge appears after reset.
   always_ff @(posedge clk) begin
      prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = prev_q & ~sig;
endmodule

// File: rtl/sdd_shift_chain.sv
module sdd_shift_chain #(
   parameter int NSTAGE = 38,
   parameter int TAP    = 38
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_edge,
   input  logic              out_edge,
   input  logic              sel_n,
   input  logic              din,
   output logic [NSTAGE-1:0] sr_q,
   output logic [NSTAGE-1:0] sr_nxt,
   output logic              dout_q
);
   localparam int TAP_IDX = TAP - 1;

   always_comb begin
      sr_nxt = sr_q;
      if (shift_edge && !sel_n) begin
         sr_nxt = {sr_q[NSTAGE-2:0], din};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q <= '0;
      end else begin
         sr_q <= sr_nxt;
      end
   end

   logic tap_bit;
   generate
      if (TAP_IDX == NSTAGE - 1) begin : g_tap_last
         assign tap_bit = sr_q[NSTAGE-1];
      end else begin : g_tap_mid
         assign tap_bit = sr_q[TAP_IDX];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q <= 1'b0;
      end else if (out_edge) begin
         dout_q <= tap_bit;
      end
   end
endmodule

// File: rtl/sdd_hold_latch.sv
module sdd_hold_latch #(
   parameter int W = 38
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/sdd_bp_gen.sv
module sdd_bp_gen
   import sdd_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter bit SELF_OSC = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic disp_clk,
   input  logic bp_mode,
   output logic bp
);
   logic    dclk_prev_q;
   logic    bp_div;
   bp_src_e src;

   always_ff @(posedge clk) begin
      dclk_prev_q <= disp_clk;
   end

   generate
      if (SELF_OSC) begin : g_div
         logic [DIV_W-1:0] cnt_q;
         logic             dclk_rise;
         assign dclk_rise = disp_clk & ~dclk_prev_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (dclk_rise) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign bp_div = cnt_q[DIV_W-1];
      end else begin : g_nodiv
         assign bp_div = dclk_prev_q;
      end
   endgenerate

   assign src = bp_src_e'(bp_mode);
   assign bp  = (src == BP_EXTERNAL) ? dclk_prev_q : bp_div;
endmodule

// File: rtl/serial_seg_driver.sv
module serial_seg_driver
   import sdd_pkg::*;
#(
   parameter int NSTAGE   = 38,
   parameter int TAP      = 38,
   parameter int DIV_W    = 8,
   parameter bit SELF_OSC = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              sel_n,
   input  logic              load,
   input  logic              disp_clk,
   input  logic              bp_mode,
   output logic [NSTAGE-1:0] seg_out,
   output logic              bp_out,
   output logic              ser_dout
);
   generate
      if (!tap_is_legal(TAP, NSTAGE)) begin : g_bad_tap
         $error("serial_seg_driver: TAP must be 30, 32, 34 or 38 and fit NSTAGE");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("serial_seg_driver: DIV_W must be at least 1");
      end
   endgenerate

   logic              cl_rise;
   logic              cl_fall;
   logic [NSTAGE-1:0] sr_q;
   logic [NSTAGE-1:0] sr_nxt;
   logic [NSTAGE-1:0] latch_q;

   sdd_edge_det u_cl_edge (
      .clk  (clk),
      .sig  (ser_clk),
      .rise (cl_rise),
      .fall (cl_fall)
   );

   sdd_shift_chain #(
      .NSTAGE (NSTAGE),
      .TAP    (TAP)
   ) u_chain (
      .clk        (clk),
      .rst        (rst),
      .shift_edge (cl_fall),
      .out_edge   (cl_rise),
      .sel_n      (sel_n),
      .din        (ser_din),
      .sr_q       (sr_q),
      .sr_nxt     (sr_nxt),
      .dout_q     (ser_dout)
   );

   // The next-state input makes the register follow the shift with no lag while load is high.
   sdd_hold_latch #(
      .W (NSTAGE)
   ) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (sr_nxt),
      .q    (latch_q)
   );

   sdd_bp_gen #(
      .DIV_W    (DIV_W),
      .SELF_OSC (SELF_OSC)
   ) u_bp (
      .clk      (clk),
      .rst      (rst),
      .disp_clk (disp_clk),
      .bp_mode  (bp_mode),
      .bp       (bp_out)
   );

   assign seg_out = latch_q ^ {NSTAGE{bp_out}};
endmodule

// File: rtl/serial_seg_driver_chk.sv
module serial_seg_driver_chk #(
   parameter int NSTAGE = 38
) (
   input logic              clk,
   input logic              rst,
   input logic              ser_clk,
   input logic              sel_n,
   input logic              load,
   input logic              disp_clk,
   input logic              bp_mode,
   input logic              ser_dout,
   input logic              bp_out,
   input logic [NSTAGE-1:0] sr_q,
   input logic [NSTAGE-1:0] latch_q
);
   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> ((sr_q == '0) && (latch_q == '0) && !ser_dout));

   assert_deselect_holds_R3: assert property (@(posedge clk) disable iff (rst)
      sel_n |=> $stable(sr_q));

   assert_dout_rise_only_R4: assert property (@(posedge clk) disable iff (rst)
      !(ser_clk && !$past(ser_clk)) |=> $stable(ser_dout));

   assert_latch_holds_R5: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(latch_q));

   assert_transparent_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> (latch_q == sr_q));

   assert_ext_backplane_R9: assert property (@(posedge clk) disable iff (rst)
      bp_mode |-> (bp_out == $past(disp_clk)));
endmodule

bind serial_seg_driver serial_seg_driver_chk #(.NSTAGE(NSTAGE)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ser_clk  (ser_clk),
   .sel_n    (sel_n),
   .load     (load),
   .disp_clk (disp_clk),
   .bp_mode  (bp_mode),
   .ser_dout (ser_dout),
   .bp_out   (bp_out),
   .sr_q     (sr_q),
   .latch_q  (latch_q)
);

// File: tb/sim_serial_seg_driver.sv
module sim_serial_seg_driver;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 38;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk = 1'b1;
   logic ser_din = 1'b0;
   logic sel_n = 1'b0;
   logic load = 1'b0;
   logic disp_clk = 1'b0;
   logic bp_mode = 1'b0;

   logic [N-1:0] seg0, seg1;
   logic         bp0, bp1, dout0, dout1;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [N-1:0] m0, m1, l0, l1;
   logic         md0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_seg_driver #(.NSTAGE(N), .TAP(32)) u0 (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din), .sel_n(sel_n),
      .load(load), .disp_clk(disp_clk), .bp_mode(bp_mode),
      .seg_out(seg0), .bp_out(bp0), .ser_dout(dout0)
   );

   serial_seg_driver #(.NSTAGE(N), .TAP(38)) u1 (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(dout0), .sel_n(sel_n),
      .load(load), .disp_clk(disp_clk), .bp_mode(bp_mode),
      .seg_out(seg1), .bp_out(bp1), .ser_dout(dout1)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit pat(input int i, input int s);
      return ((i * s + (i >> 2)) % 3) == 0;
   endfunction

   task automatic model_reset();
      m0 = '0; m1 = '0; l0 = '0; l1 = '0; md0 = 1'b0;
   endtask

   task automatic cl_pulse(input bit d);
      logic prev_d0, prev_d1;
      prev_d0 = dout0;
      prev_d1 = dout1;
      ser_din = d;
      ser_clk = 1'b0;
      tick(2);
      if (!sel_n) begin
         m1 = {m1[N-2:0], md0};
         m0 = {m0[N-2:0], d};
      end
      if (load) begin l0 = m0; l1 = m1; end
      check("R4 dout0 steady after fall", 64'(dout0), 64'(prev_d0));
      check("R4 dout1 steady after fall", 64'(dout1), 64'(prev_d1));
      ser_clk = 1'b1;
      tick(2);
      md0 = m0[31];
      check("R4 dout0 tap32 after rise", 64'(dout0), 64'(md0));
      check("R4 dout1 tap38 after rise", 64'(dout1), 64'(m1[N-1]));
   endtask

   task automatic load_pulse();
      load = 1'b1;
      tick(1);
      load = 1'b0;
      tick(1);
      l0 = m0; l1 = m1;
   endtask

   task automatic dclk_pulse();
      disp_clk = 1'b1;
      tick(1);
      disp_clk = 1'b0;
      tick(1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      tick(3);
      rst = 1'b0;
      tick(1);

      // R1 reset state
      check("R1 seg0 blank", 64'(seg0), 64'(0));
      check("R1 seg1 blank", 64'(seg1), 64'(0));
      check("R1 bp low", 64'(bp0), 64'(0));
      check("R1 dout low", 64'(dout0), 64'(0));

      // R2 / R5: shift a full pattern with load low, display must hold
      for (int i = 0; i < N; i++) cl_pulse(pat(i, 5));
      check("R5 latch holds while load low", 64'(seg0), 64'(0));
      load_pulse();
      check("R2 shifted pattern loaded u0", 64'(seg0), 64'(l0));
      check("R10 chained pattern loaded u1", 64'(seg1), 64'(l1));

      // R3: deselected shifts ignored
      sel_n = 1'b1;
      for (int i = 0; i < 6; i++) cl_pulse(1'b1);
      load_pulse();
      check("R3 register unchanged while deselected", 64'(seg0), 64'(l0));
      sel_n = 1'b0;

      // R6: transparent load
      load = 1'b1;
      for (int i = 0; i < 10; i++) begin
         cl_pulse(pat(i, 3));
         check("R6 latch follows register", 64'(seg0), 64'(m0));
      end
      load = 1'b0;
      tick(1);

      // R10: longer chained run
      for (int i = 0; i < 70; i++) cl_pulse(pat(i, 11));
      load_pulse();
      check("R10 upstream after long run", 64'(seg0), 64'(l0));
      check("R10 downstream after long run", 64'(seg1), 64'(l1));

      // R8 / R7: divided backplane
      for (int i = 0; i < 127; i++) dclk_pulse();
      check("R8 bp low after 127 edges", 64'(bp0), 64'(0));
      dclk_pulse();
      check("R8 bp high after 128 edges", 64'(bp0), 64'(1));
      check("R7 segments antiphase when bp high", 64'(seg0), 64'(l0 ^ {N{1'b1}}));
      for (int i = 0; i < 127; i++) dclk_pulse();
      check("R8 bp high after 255 edges", 64'(bp0), 64'(1));
      dclk_pulse();
      check("R8 bp low after 256 edges", 64'(bp0), 64'(0));
      check("R7 segments equal held bits when bp low", 64'(seg0), 64'(l0));

      // R9: external backplane
      bp_mode = 1'b1;
      disp_clk = 1'b1;
      tick(1);
      check("R9 bp follows display clock high", 64'(bp1), 64'(1));
      check("R7 external antiphase u1", 64'(seg1), 64'(l1 ^ {N{1'b1}}));
      disp_clk = 1'b0;
      tick(1);
      check("R9 bp follows display clock low", 64'(bp1), 64'(0));
      check("R7 external in phase u1", 64'(seg1), 64'(l1));
      bp_mode = 1'b0;
      tick(1);

      // R1: reset mid-run
      rst = 1'b1;
      tick(2);
      rst = 1'b0;
      model_reset();
      tick(1);
      check("R1 seg0 cleared by reset", 64'(seg0), 64'(0));
      check("R1 seg1 cleared by reset", 64'(seg1), 64'(0));
      check("R1 dout cleared by reset", 64'(dout0), 64'(0));
      check("R1 bp low after reset", 64'(bp0), 64'(0));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule